// File: doc/BRIEF.md
# Mode-Selectable Feedback Shift Counter

This block is a small shift register that feeds itself. Each stage passes its bit to the next stage on every enabled clock edge. Stage 0 (QA) is the entry point and stage WIDTH-1 (QD) is the far end. The bit that enters stage 0 is computed from the register's own contents. A two-bit mode input picks how that bit is formed:

- **Plain rotation:** the far-end bit comes back unchanged.
- **Twisted rotation:** the inverted far-end bit comes back.
- **Linear feedback:** the XOR of the two highest stages comes back. With four stages this walks through all 15 nonzero states.

Before counting starts, the register is preset from a parallel seed. A shift-enable input freezes the register, so a running pseudo-random value can be captured and held. The enable works as a clock enable on the flops; the clock itself is never gated. The whole state is visible on a registered output.

Top module: `fsc_counter`

## Requirements
- R1: A high `rst` at a rising clock edge sets `state` to all zeros on that edge. This holds whatever `load`, `shift_en` and `mode` are doing.
- R2: With `rst` low and `load` high, `state` takes the value of `seed` at the edge, whatever `shift_en` and `mode` are.
- R3: With `rst`, `load` and `shift_en` all low, `state` keeps its value across the edge.
- R4: With `shift_en` high and `load` and `rst` low, each `state[i+1]` takes the old `state[i]`. The feedback bit enters `state[0]`.
- R5: With `mode` = 2'b00, the feedback bit is the old `state[WIDTH-1]`. A seed of 4'b0001 returns to itself after 4 shifts.
- R6: With `mode` = 2'b01, the feedback bit is the inverse of the old `state[WIDTH-1]`. A seed of 4'b0000 runs through 8 distinct states: 0001, 0011, 0111, 1111, 1110, 1100, 1000, 0000.
- R7: With `mode` = 2'b10, the feedback bit is the old `state[WIDTH-1]` XOR `state[WIDTH-2]`. A seed of 4'b0001 returns to itself after exactly 15 shifts and not before.
- R8: `mode` = 2'b11 gives the same feedback as `mode` = 2'b00.
- R9: In `mode` = 2'b10, an all-zero state stays all zero while shifting, until a nonzero seed is loaded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high clear |
| load | input | 1 | Parallel preset from `seed` |
| seed | input | WIDTH | Preset value |
| mode | input | 2 | Feedback rule: 00 rotate, 01 twisted, 10 linear XOR, 11 rotate |
| shift_en | input | 1 | Advance the register when high, hold when low |
| state | output | WIDTH | Registered stage contents, bit 0 is the entry stage |

## Verification
Loading and shifting can both be requested in the same cycle. Clear can also coincide with both of them. The bench drives `load` together with `shift_en` while the register holds a nonzero running value, and checks that the next state equals the seed rather than the shifted value. It also raises `rst` alongside `load` and `shift_en` with an all-ones seed, and expects zeros one edge later.

// File: rtl/fsc_pkg.sv
package fsc_pkg;
  typedef enum logic [1:0] {
    FB_ROTATE  = 2'b00,
    FB_TWIST   = 2'b01,
    FB_LINEAR  = 2'b10,
    FB_ROT_ALT = 2'b11
  } fb_mode_e;
endpackage

// File: rtl/fsc_feedback.sv
module fsc_feedback #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic [1:0]       mode,
  output logic             fb_bit
);
  import fsc_pkg::*;
  localparam int TOP  = WIDTH - 1;
  localparam int NEXT = WIDTH - 2;

  fb_mode_e sel;
  assign sel = fb_mode_e'(mode);

  always_comb begin
    unique case (sel)
      FB_TWIST:  fb_bit = ~cur[TOP];
      FB_LINEAR: fb_bit = cur[TOP] ^ cur[NEXT];
      default:   fb_bit = cur[TOP];
    endcase
  end
endmodule

// File: rtl/fsc_next_state.sv
module fsc_next_state #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] cur,
  input  logic             fb_bit,
  output logic [WIDTH-1:0] nxt
);
  assign nxt[0] = fb_bit;
  for (genvar i = 1; i < WIDTH; i++) begin : g_stage
    assign nxt[i] = cur[i-1];
  end
endmodule

// File: rtl/fsc_stage_reg.sv
module fsc_stage_reg #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             shift_en,
  input  logic [WIDTH-1:0] seed,
  input  logic [WIDTH-1:0] nxt,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)           q <= '0;
    else if (load)     q <= seed;
    else if (shift_en) q <= nxt;
  end
endmodule

// File: rtl/fsc_counter.sv
module fsc_counter #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [WIDTH-1:0] seed,
  input  logic [1:0]       mode,
  input  logic             shift_en,
  output logic [WIDTH-1:0] state
);
  logic             fb_bit;
  logic [WIDTH-1:0] nxt;

  fsc_feedback #(.WIDTH(WIDTH)) u_fb (
    .cur(state), .mode(mode), .fb_bit(fb_bit)
  );

  fsc_next_state #(.WIDTH(WIDTH)) u_nxt (
    .cur(state), .fb_bit(fb_bit), .nxt(nxt)
  );

  fsc_stage_reg #(.WIDTH(WIDTH)) u_reg (
    .clk(clk), .rst(rst), .load(load), .shift_en(shift_en),
    .seed(seed), .nxt(nxt), .q(state)
  );
endmodule

// File: rtl/fsc_counter_chk.sv
module fsc_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             load,
  input logic [WIDTH-1:0] seed,
  input logic [1:0]       mode,
  input logic             shift_en,
  input logic [WIDTH-1:0] state
);
  logic rst_q;
  always_ff @(posedge clk) rst_q <= rst;

  always @(posedge clk) begin
    if (rst_q == 1'b1) begin
      AST_RESET_ZERO: assert (state == '0) else $error("clear failed"); // R1
    end
  end

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (rst)
    load |=> state == $past(seed)); // R2
  AST_HOLD_STILL: assert property (@(posedge clk) disable iff (rst)
    (!load && !shift_en) |=> $stable(state)); // R3
  AST_SHIFT_UP: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_en) |=> state[WIDTH-1:1] == $past(state[WIDTH-2:0])); // R4
  AST_ROTATE_FB: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_en && mode == 2'b00) |=> state[0] == $past(state[WIDTH-1])); // R5
  AST_TWIST_FB: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_en && mode == 2'b01) |=> state[0] != $past(state[WIDTH-1])); // R6
  AST_LINEAR_FB: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_en && mode == 2'b10)
      |=> state[0] == ($past(state[WIDTH-1]) ^ $past(state[WIDTH-2]))); // R7
  AST_ALT_ROTATE: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_en && mode == 2'b11) |=> state[0] == $past(state[WIDTH-1])); // R8
  AST_ZERO_LOCK: assert property (@(posedge clk) disable iff (rst)
    (!load && shift_en && mode == 2'b10 && state == '0) |=> state == '0); // R9
endmodule

bind fsc_counter fsc_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk(clk), .rst(rst), .load(load), .seed(seed),
  .mode(mode), .shift_en(shift_en), .state(state)
);

// File: tb/fsc_counter_tb.sv
`timescale 1ns/1ps
module fsc_counter_tb;
  localparam int W = 4;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         load = 1'b0;
  logic [W-1:0] seed = '0;
  logic [1:0]   mode = 2'b00;
  logic         shift_en = 1'b0;
  logic [W-1:0] state;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  fsc_counter #(.WIDTH(W)) u_dut (
    .clk(clk), .rst(rst), .load(load), .seed(seed),
    .mode(mode), .shift_en(shift_en), .state(state)
  );

  // {load, shift_en, mode[1:0], seed[3:0], expected[3:0]}
  localparam int NV = 15;
  localparam logic [11:0] VEC [NV] = '{
    {1'b1, 1'b0, 2'b00, 4'b0001, 4'b0001}, // R2 preset
    {1'b0, 1'b1, 2'b00, 4'b0000, 4'b0010}, // R5
    {1'b0, 1'b1, 2'b00, 4'b0000, 4'b0100}, // R5
    {1'b0, 1'b0, 2'b00, 4'b1111, 4'b0100}, // R3 hold
    {1'b1, 1'b0, 2'b01, 4'b0000, 4'b0000}, // R2
    {1'b0, 1'b1, 2'b01, 4'b0000, 4'b0001}, // R6
    {1'b0, 1'b1, 2'b01, 4'b0000, 4'b0011}, // R6
    {1'b0, 1'b1, 2'b01, 4'b0000, 4'b0111}, // R6
    {1'b1, 1'b1, 2'b10, 4'b0001, 4'b0001}, // R2 load beats shift
    {1'b0, 1'b1, 2'b10, 4'b0000, 4'b0010}, // R7
    {1'b0, 1'b1, 2'b10, 4'b0000, 4'b0100}, // R7
    {1'b0, 1'b1, 2'b10, 4'b0000, 4'b1001}, // R7
    {1'b0, 1'b1, 2'b11, 4'b0000, 4'b0011}, // R8
    {1'b1, 1'b0, 2'b10, 4'b0000, 4'b0000}, // R2 zero seed
    {1'b0, 1'b1, 2'b10, 4'b0000, 4'b0000}  // R9 lock
  };

  function automatic logic [W-1:0] model(input logic [W-1:0] q, input logic [1:0] m);
    logic b;
    case (m)
      2'b01:   b = ~q[W-1];
      2'b10:   b = q[W-1] ^ q[W-2];
      default: b = q[W-1];
    endcase
    return {q[W-2:0], b};
  endfunction

  task automatic chk(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: state=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic r, input logic ld, input logic en,
                      input logic [1:0] m, input logic [W-1:0] s);
    @(negedge clk);
    rst = r; load = ld; shift_en = en; mode = m; seed = s;
    @(posedge clk);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: state=%b expected=done", state);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    logic [W-1:0] ref_q;
    logic [W-1:0] seeds [4];
    seeds[0] = 4'b0001; seeds[1] = 4'b0000; seeds[2] = 4'b0001; seeds[3] = 4'b0101;

    // R1: clear beats load and shift
    step(1'b1, 1'b1, 1'b1, 2'b10, 4'b1111);
    chk("R1 reset", state, 4'b0000);

    for (int i = 0; i < NV; i++) begin
      step(1'b0, VEC[i][11], VEC[i][10], VEC[i][9:8], VEC[i][7:4]);
      chk($sformatf("R2-R9 vector %0d", i), state, VEC[i][3:0]);
    end

    // R4-R8: 20 shifts in each mode against a model
    for (int m = 0; m < 4; m++) begin
      step(1'b0, 1'b1, 1'b0, 2'(m), seeds[m]);
      ref_q = seeds[m];
      for (int k = 0; k < 20; k++) begin
        step(1'b0, 1'b0, 1'b1, 2'(m), 4'b0000);
        ref_q = model(ref_q, 2'(m));
        chk($sformatf("R4 mode %0d shift %0d", m, k), state, ref_q);
      end
    end

    // R6: twisted sequence length 8
    step(1'b0, 1'b1, 1'b0, 2'b01, 4'b0000);
    for (int k = 1; k <= 8; k++) begin
      step(1'b0, 1'b0, 1'b1, 2'b01, 4'b0000);
      n_chk++;
      if ((k < 8 && state == 4'b0000) || (k == 8 && state != 4'b0000)) begin
        n_bad++;
        $display("FAIL R6 period step %0d: state=%b expected=%s", k, state,
                 (k == 8) ? "0000" : "nonzero");
      end
    end

    // R7: linear mode returns to seed after exactly 15 shifts
    step(1'b0, 1'b1, 1'b0, 2'b10, 4'b0001);
    for (int k = 1; k <= 15; k++) begin
      step(1'b0, 1'b0, 1'b1, 2'b10, 4'b0000);
      n_chk++;
      if ((k < 15 && state == 4'b0001) || (k == 15 && state != 4'b0001)) begin
        n_bad++;
        $display("FAIL R7 period step %0d: state=%b expected=%s", k, state,
                 (k == 15) ? "0001" : "not 0001");
      end
    end

    // R3: freeze a running random value over several cycles
    step(1'b0, 1'b0, 1'b1, 2'b10, 4'b0000);
    ref_q = state;
    for (int k = 0; k < 3; k++) begin
      step(1'b0, 1'b0, 1'b0, 2'b10, 4'b1010);
      chk("R3 freeze", state, ref_q);
    end

    // R1: clear mid-run with load and shift requested
    step(1'b1, 1'b1, 1'b1, 2'b00, 4'b1111);
    chk("R1 mid-run clear", state, 4'b0000);

    // R9: zero after clear stays zero in linear mode, escapes on load
    step(1'b0, 1'b0, 1'b1, 2'b10, 4'b0000);
    chk("R9 locked", state, 4'b0000);
    step(1'b0, 1'b1, 1'b1, 2'b10, 4'b1000);
    chk("R9 reseed", state, 4'b1000);
    step(1'b0, 1'b0, 1'b1, 2'b10, 4'b0000);
    chk("R9 resumes", state, 4'b0001);

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule